// File: doc/BRIEF.md
# Round-Robin Stream Merger with Sync Removal

This block gathers tagged 28-bit words from several deserializer lanes and merges them into one stream that is written into a downstream FIFO. Each word has a 4-bit chip tag in its upper bits and a 24-bit payload below it. Every lane has a one-word holding slot. A slot counter steps through the lanes, one lane per clock, and uses a multiplexer to offer the selected slot to the output.

When a slot is visited, its word is removed from the slot. A word that carries the sync flag is dropped at that point and is never written. Only payload words produce a FIFO write. A full indication from the FIFO freezes the slot counter and blocks writes. Held words stay in place until the FIFO has room again.

If a lane delivers a new word while its slot is still occupied, the new word is lost. A per-lane sticky error bit records that this happened.

Top module: `chan_merge`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, `out_wr` is 0 and `ovr_err` is all zeros. The slot counter starts at lane 0. Only a reset clears `ovr_err`.
- R2: When `fifo_full` is low, the slot counter advances by exactly one lane per clock in the order 0, 1, …, N_CH-1 and wraps from N_CH-1 back to 0. Lanes that all hold data words are therefore written in that order, one per cycle.
- R3: A word that arrives with its sync flag set is discarded when its lane is visited. It never causes a write, and it frees the slot so that a later word can load without error.
- R4: A data word is written unchanged as all 28 bits: tag in [27:24], payload in [23:0]. The write happens in the cycle its lane is selected.
- R5: A visited lane whose slot is empty produces no write. A word is written only once.
- R6: A word that arrives while its lane's slot is occupied and not being taken that cycle is dropped. The held word is kept, and that lane's bit of `ovr_err` becomes 1 and stays 1.
- R7: A word that arrives in the same cycle its lane's slot is taken loads into the slot without flagging an error.
- R8: When `fifo_full` is high, `out_wr` is 0, the counter holds its lane, and held words keep their values. After `fifo_full` falls, the write resumes at the same lane.
- R9: `out_wr` is 1 only when the selected slot holds a word, that word's sync flag is clear, and `fifo_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_words | input | N_CH*28 | Lane words, lane c at bits [c*28 +: 28] |
| in_valid | input | N_CH | A word is present on the lane this cycle |
| in_sync | input | N_CH | The lane's word is a sync word |
| fifo_full | input | 1 | Downstream FIFO cannot accept a write |
| out_data | output | 28 | Merged word toward the FIFO |
| out_wr | output | 1 | Write enable toward the FIFO |
| ovr_err | output | N_CH | Sticky per-lane overrun flags |

## Verification
A single payload word on one lane shows that it appears exactly once, only in that lane's slot, and with all 28 bits intact. Loading all lanes in the same cycle shows the visiting order and the wrap from the last lane back to lane 0. A sync word followed by a data word on the same lane separates the case where a sync word is dropped from the case where it is left blocking the slot. Holding `fifo_full` high over a pending slot, an arrival timed into an occupied slot, and an arrival in the same cycle the slot is taken separate three things: counter stall, error-flag-and-keep-old, and a clean reload.

// File: rtl/chm_pkg.sv
package chm_pkg;
  parameter int unsigned PAYLOAD_W = 24;
  parameter int unsigned TAG_W     = 4;
  parameter int unsigned WORD_W    = PAYLOAD_W + TAG_W;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/chm_slot_counter.sv
module chm_slot_counter #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [SEL_W-1:0] sel
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N_CH - 1);

  logic [SEL_W-1:0] sel_nxt;

  always_comb begin
    sel_nxt = sel;
    if (adv) begin
      if (sel == LAST) sel_nxt = '0;
      else             sel_nxt = sel + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= '0;
    else        sel <= sel_nxt;
  end

  p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel <= LAST);
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sel == LAST) |=> (sel == '0));
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(sel));
endmodule

// File: rtl/chm_hold_reg.sv
module chm_hold_reg
  import chm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t in_word,
  input  logic  in_valid,
  input  logic  in_sync,
  input  logic  take,
  output word_t hold_word,
  output logic  hold_valid,
  output logic  hold_sync,
  output logic  overrun
);
  logic load;
  logic valid_nxt;
  logic err_nxt;

  always_comb begin
    load      = in_valid && (!hold_valid || take);
    valid_nxt = hold_valid;
    if (load)      valid_nxt = 1'b1;
    else if (take) valid_nxt = 1'b0;
    err_nxt   = overrun || (in_valid && hold_valid && !take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      hold_valid <= valid_nxt;
      overrun    <= err_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      hold_sync <= 1'b0;
    end else if (load) begin
      hold_word <= in_word;
      hold_sync <= in_sync;
    end
  end

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && !take) |=> (hold_valid && $stable(hold_word) && $stable(hold_sync)));
endmodule

// File: rtl/chm_word_mux.sv
module chm_word_mux
  import chm_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic [SEL_W-1:0]             sel,
  input  logic [N_CH-1:0][WORD_W-1:0]  words,
  input  logic [N_CH-1:0]              valids,
  input  logic [N_CH-1:0]              syncs,
  output word_t                        word,
  output logic                         valid,
  output logic                         sync
);
  always_comb begin
    word  = '0;
    valid = 1'b0;
    sync  = 1'b0;
    for (int c = 0; c < int'(N_CH); c++) begin
      if (sel == SEL_W'(c)) begin
        word  = words[c];
        valid = valids[c];
        sync  = syncs[c];
      end
    end
  end
endmodule

// File: rtl/chan_merge.sv
module chan_merge
  import chm_pkg::*;
#(
  parameter int unsigned N_CH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH*WORD_W-1:0]   in_words,
  input  logic [N_CH-1:0]          in_valid,
  input  logic [N_CH-1:0]          in_sync,
  input  logic                     fifo_full,
  output logic [WORD_W-1:0]        out_data,
  output logic                     out_wr,
  output logic [N_CH-1:0]          ovr_err
);
  localparam int unsigned SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [1:0]                rst_pipe;
  logic                      rst_int_n;
  logic                      adv;
  logic [SEL_W-1:0]          sel;
  logic [N_CH-1:0]           take;
  logic [N_CH-1:0][WORD_W-1:0] hold_words;
  logic [N_CH-1:0]           hold_valids;
  logic [N_CH-1:0]           hold_syncs;
  word_t                     mux_word;
  logic                      mux_valid;
  logic                      mux_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign adv = !fifo_full;

  chm_slot_counter #(.N_CH(N_CH), .SEL_W(SEL_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .adv   (adv),
    .sel   (sel)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    assign take[c] = adv && (sel == SEL_W'(c));
    chm_hold_reg u_hold (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .in_word    (in_words[c*WORD_W +: WORD_W]),
      .in_valid   (in_valid[c]),
      .in_sync    (in_sync[c]),
      .take       (take[c]),
      .hold_word  (hold_words[c]),
      .hold_valid (hold_valids[c]),
      .hold_sync  (hold_syncs[c]),
      .overrun    (ovr_err[c])
    );
  end

  chm_word_mux #(.N_CH(N_CH), .SEL_W(SEL_W)) u_mux (
    .sel    (sel),
    .words  (hold_words),
    .valids (hold_valids),
    .syncs  (hold_syncs),
    .word   (mux_word),
    .valid  (mux_valid),
    .sync   (mux_sync)
  );

  assign out_wr   = mux_valid && !mux_sync && adv;
  assign out_data = mux_word;

  p_wr_nonsync_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_wr |-> !mux_sync);
  p_no_wr_full_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    fifo_full |-> !out_wr);
  p_wr_held_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_wr |-> $onehot0(take & hold_valids) && (take & hold_valids) != '0);
  p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_wr && !in_valid[sel]) |=> !(hold_valids[$past(sel)]));
endmodule

// File: tb/chan_merge_tb.sv
`timescale 1ns/1ps
module chan_merge_tb;
  import chm_pkg::*;
  localparam int N = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N*WORD_W-1:0] in_words;
  logic [N-1:0]      in_valid;
  logic [N-1:0]      in_sync;
  logic              fifo_full;
  logic [WORD_W-1:0] out_data;
  logic              out_wr;
  logic [N-1:0]      ovr_err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  chan_merge #(.N_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_words(in_words), .in_valid(in_valid),
    .in_sync(in_sync), .fifo_full(fifo_full), .out_data(out_data),
    .out_wr(out_wr), .ovr_err(ovr_err)
  );

  // Expected slot, from R1/R2/R8: starts at 0, runs after two edges past reset release.
  logic d1, d2;
  int   bsel;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 <= 1'b0; d2 <= 1'b0; bsel <= 0;
    end else begin
      d1 <= 1'b1; d2 <= d1;
      if (d2 && !fifo_full) bsel <= (bsel + 1) % N;
    end
  end

  function automatic word_t mk(int tag, int pay);
    return {TAG_W'(tag), PAYLOAD_W'(pay)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(int ch, word_t w, bit s);
    in_words[ch*WORD_W +: WORD_W] = w;
    in_valid[ch] = 1'b1;
    in_sync[ch]  = s;
  endtask

  task automatic idle();
    in_valid = '0;
    in_sync  = '0;
  endtask

  task automatic wait_sel(int k);
    @(negedge clk);
    while (bsel != k) @(negedge clk);
  endtask

  // One full lap, starting at a negedge: only lane ch may write, with word w if exp_wr.
  task automatic lap(int ch, word_t w, bit exp_wr, string req);
    for (int i = 0; i < N; i++) begin
      #1;
      if (bsel == ch) begin
        chk(out_wr == exp_wr, req, "out_wr at own slot", 32'(out_wr), 32'(exp_wr));
        if (exp_wr) chk(out_data == w, req, "out_data", 32'(out_data), 32'(w));
      end else begin
        chk(out_wr == 1'b0, req, "out_wr at other slot", 32'(out_wr), 0);
      end
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fifo_full = 1'b0; idle(); in_words = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_wr == 1'b0, "R1", "out_wr in reset", 32'(out_wr), 0);
    chk(ovr_err == '0, "R1", "ovr_err in reset", 32'(ovr_err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(out_wr == 1'b0, "R1", "out_wr after reset", 32'(out_wr), 0);
    chk(ovr_err == '0, "R1", "ovr_err after reset", 32'(ovr_err), 0);
  endtask

  task automatic t_single();
    word_t w = mk(2, 24'h5A1C3E);
    wait_sel(3); put(2, w, 1'b0);
    @(negedge clk); idle();
    lap(2, w, 1'b1, "R4");
    lap(2, w, 1'b0, "R5");
  endtask

  task automatic t_order();
    word_t w [N];
    for (int c = 0; c < N; c++) w[c] = mk(c + 8, 24'h100 * (c + 1) + 24'h0F);
    wait_sel(0);
    for (int c = 0; c < N; c++) put(c, w[c], 1'b0);
    @(negedge clk); idle();
    for (int i = 0; i < N; i++) begin
      int e = (1 + i) % N;
      #1;
      chk(out_wr == 1'b1, "R2", "out_wr in sequence", 32'(out_wr), 1);
      chk(out_data == w[e], "R2", "lane order/wrap", 32'(out_data), 32'(w[e]));
      @(negedge clk);
    end
    #1;
    chk(out_wr == 1'b0, "R5", "no write after lap", 32'(out_wr), 0);
  endtask

  task automatic t_sync();
    word_t ws = mk(1, 24'hFFF000);
    word_t wd = mk(1, 24'h00ABCD);
    wait_sel(0); put(1, ws, 1'b1);
    @(negedge clk); idle();
    lap(1, ws, 1'b0, "R3");
    put(1, wd, 1'b0);
    @(negedge clk); idle();
    lap(1, wd, 1'b1, "R3");
    #1;
    chk(ovr_err == '0, "R3", "sync freed slot", 32'(ovr_err), 0);
  endtask

  task automatic t_full();
    word_t w = mk(3, 24'h777777);
    wait_sel(0); put(3, w, 1'b0);
    @(negedge clk); idle();
    wait_sel(3);
    fifo_full = 1'b1;
    #1;
    chk(out_wr == 1'b0, "R8", "blocked while full", 32'(out_wr), 0);
    repeat (3) begin
      @(negedge clk); #1;
      chk(out_wr == 1'b0, "R8", "blocked while full", 32'(out_wr), 0);
    end
    @(negedge clk);
    fifo_full = 1'b0;
    #1;
    chk(out_wr == 1'b1, "R8", "resume at same lane", 32'(out_wr), 1);
    chk(out_data == w, "R8", "held word kept", 32'(out_data), 32'(w));
    @(negedge clk); #1;
    chk(out_wr == 1'b0, "R9", "slot emptied", 32'(out_wr), 0);
  endtask

  task automatic t_overrun();
    word_t wa = mk(0, 24'h0A0A0A);
    word_t wb = mk(0, 24'h0B0B0B);
    do_reset();
    wait_sel(1); put(0, wa, 1'b0);
    @(negedge clk); put(0, wb, 1'b0);
    @(negedge clk); idle();
    lap(0, wa, 1'b1, "R6");
    #1;
    chk(ovr_err == 4'b0001, "R6", "overrun flag", 32'(ovr_err), 1);
    @(negedge clk);
    lap(0, wa, 1'b0, "R6");
    #1;
    chk(ovr_err == 4'b0001, "R6", "flag sticky", 32'(ovr_err), 1);
    do_reset();
  endtask

  task automatic t_same_cycle();
    word_t wx = mk(2, 24'h123456);
    word_t wy = mk(2, 24'h654321);
    wait_sel(0); put(2, wx, 1'b0);
    @(negedge clk); idle();
    @(negedge clk);
    put(2, wy, 1'b0);
    #1;
    chk(out_wr == 1'b1, "R7", "old word written", 32'(out_wr), 1);
    chk(out_data == wx, "R7", "old word data", 32'(out_data), 32'(wx));
    @(negedge clk); idle();
    lap(2, wy, 1'b1, "R7");
    #1;
    chk(ovr_err == '0, "R7", "no overrun", 32'(ovr_err), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_single();
    t_order();
    t_sync();
    t_full();
    t_overrun();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule